// File: doc/BRIEF.md
# Signed-Duty PWM Bank with Direction Pins

This block drives a bank of servo channels from signed duty commands. A single free-running counter sets a common PWM period, and each channel turns its command into sign and magnitude. When the command is positive, the magnitude appears as pulses on the channel's forward pin. When it is negative, the pulses appear on the reverse pin. Both pins of a channel are never driven by the pulse train at the same time.

Each pin passes through an exclusive-OR with its own general-purpose output bit. Setting the bit inverts the pin's sense, which makes it active low. When the channel is held at zero, the bit alone sets the pin, so the pin works as a plain output. A host writes each channel's command with that channel's own strobe. The command waits in a holding register and reaches the comparator only at the counter wrap, so a period is never cut short or stretched. A status LED shows the combined activity of channel 0's two pins.

Top module: `sm_pwm_bank`

## Requirements
- R1: A positive command d drives the forward pin high for exactly d clocks out of every 2^(DUTY_W-1) clocks, which is 2048 at the default DUTY_W of 12. The reverse pin stays low, provided both polarity bits are clear.
- R2: A negative command d drives the reverse pin high for exactly |d| clocks per period, and the forward pin stays low, provided both polarity bits are clear.
- R3: A command of zero holds both pins inactive for the whole period.
- R4: Each pin equals its PWM signal XOR its polarity bit (pol_up[k] for the forward pin, pol_dn[k] for the reverse pin). A change of the bit shows on the pin at the next clock edge. Under a zero command, the pin equals the bit.
- R5: led_o equals the OR of up_o[0] and dn_o[0] in every cycle.
- R6: duty_wr[k] loads duty_in[k*DUTY_W +: DUTY_W] into channel k only. The other channels keep their outputs unchanged.
- R7: A written command takes effect only after the counter wraps from its maximum value to 0. A write in mid-period leaves the rest of the current period unchanged.
- R8: While rst is high and on the first cycle after it drops, every pin and led_o is low, provided the polarity bits are clear.
- R9: Full-scale commands are exact. +2047 gives 2047 high clocks out of 2048. -2048 holds the reverse pin high on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_in | input | NUM_CH*DUTY_W | Signed commands, channel k in slice k |
| duty_wr | input | NUM_CH | Per-channel command write strobe |
| pol_up | input | NUM_CH | Polarity/output bit XORed onto the forward pins |
| pol_dn | input | NUM_CH | Polarity/output bit XORed onto the reverse pins |
| up_o | output | NUM_CH | Forward pins |
| dn_o | output | NUM_CH | Reverse pins |
| led_o | output | 1 | Activity indicator for channel 0 |

## Verification
The pins are measured by counting high clocks over a full-period window after each command has settled. The commands cover small, mid-range and full-scale values of both signs, plus zero. These patterns separate correct sign steering from swapped pins, and they expose off-by-one errors in the compare and the asymmetric -2048 case. The same commands are repeated with the polarity bits set, which separates an XOR from an OR or a missing inversion. They also show the pin acting as a plain output when the command is zero. Writes to channels other than 0 are watched through the LED to confirm they stay local. A mid-period write after reset shows that a new command waits for the wrap.

// File: rtl/sm_pwm_pkg.sv
package sm_pwm_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_FWD  = 2'd1,
    DIR_REV  = 2'd2
  } pwm_dir_e;
endpackage

// File: rtl/sm_pwm_counter.sv
module sm_pwm_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_o + 1'b1;
  end

  assign wrap_o = (cnt_o == CNT_MAX);

  // R7
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_o == '0));

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_o |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/sm_pwm_chan.sv
module sm_pwm_chan
  import sm_pwm_pkg::*;
#(
  parameter int DUTY_W = 12,
  localparam int CNT_W = DUTY_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              duty_wr,
  input  logic              pol_up,
  input  logic              pol_dn,
  output logic              up_o,
  output logic              dn_o,
  output logic              any_o
);
  logic [DUTY_W-1:0] pend_q;
  logic [DUTY_W-1:0] act_q;
  logic [DUTY_W-1:0] mag;
  logic              pulse;
  pwm_dir_e          dir;
  logic              nxt_up, nxt_dn;

  // holding register, written at the host's own time
  always_ff @(posedge clk) begin
    if (rst)          pend_q <= '0;
    else if (duty_wr) pend_q <= duty_in;
  end

  // comparator value changes only at the period boundary
  always_ff @(posedge clk) begin
    if (rst)       act_q <= '0;
    else if (wrap) act_q <= pend_q;
  end

  always_comb begin
    mag   = act_q[DUTY_W-1] ? (~act_q + 1'b1) : act_q;
    pulse = ({1'b0, cnt} < mag);
    if (act_q == '0)           dir = DIR_IDLE;
    else if (act_q[DUTY_W-1])  dir = DIR_REV;
    else                       dir = DIR_FWD;
    nxt_up = ((dir == DIR_FWD) && pulse) ^ pol_up;
    nxt_dn = ((dir == DIR_REV) && pulse) ^ pol_dn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_o  <= 1'b0;
      dn_o  <= 1'b0;
      any_o <= 1'b0;
    end else begin
      up_o  <= nxt_up;
      dn_o  <= nxt_dn;
      any_o <= nxt_up | nxt_dn;
    end
  end

  // R1
  fwd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (!pol_up && !pol_dn && !act_q[DUTY_W-1]) |=> !dn_o);

  // R2
  rev_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (!pol_up && !pol_dn && act_q[DUTY_W-1]) |=> !up_o);

  // R3
  zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q == '0) |=> ((up_o == $past(pol_up)) && (dn_o == $past(pol_dn))));

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_q));
endmodule

// File: rtl/sm_pwm_bank.sv
module sm_pwm_bank #(
  parameter int NUM_CH = 4,
  parameter int DUTY_W = 12,
  localparam int CNT_W = DUTY_W - 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH*DUTY_W-1:0] duty_in,
  input  logic [NUM_CH-1:0]        duty_wr,
  input  logic [NUM_CH-1:0]        pol_up,
  input  logic [NUM_CH-1:0]        pol_dn,
  output logic [NUM_CH-1:0]        up_o,
  output logic [NUM_CH-1:0]        dn_o,
  output logic                     led_o
);
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [NUM_CH-1:0] any;

  sm_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    sm_pwm_chan #(.DUTY_W(DUTY_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .cnt     (cnt),
      .wrap    (wrap),
      .duty_in (duty_in[k*DUTY_W +: DUTY_W]),
      .duty_wr (duty_wr[k]),
      .pol_up  (pol_up[k]),
      .pol_dn  (pol_dn[k]),
      .up_o    (up_o[k]),
      .dn_o    (dn_o[k]),
      .any_o   (any[k])
    );
  end

  assign led_o = any[0];

  // R5
  led_follow_chk: assert property (@(posedge clk) disable iff (rst)
    led_o == (up_o[0] | dn_o[0]));
endmodule

// File: tb/sim_sm_pwm_bank.sv
module sim_sm_pwm_bank;
  localparam int NUM_CH = 4;
  localparam int DW     = 12;
  localparam int PER    = 2048;
  localparam int NV     = 13;

  typedef struct packed {
    int ch; int duty; int pu; int pd; int eu; int ed; int el;
  } vec_t;

  // ch, duty, pol_up, pol_dn, expected up/dn/led high clocks per window
  localparam vec_t TBL [NV] = '{
    '{0,   100, 0, 0,  100,    0,  100},
    '{0,  -300, 0, 0,    0,  300,  300},
    '{0,     0, 0, 0,    0,    0,    0},
    '{0,  2047, 0, 0, 2047,    0, 2047},
    '{0, -2048, 0, 0,    0, 2048, 2048},
    '{0,   100, 1, 0, 1948,    0, 1948},
    '{0,  -300, 1, 1, 2048, 1748, 2048},
    '{0,     0, 1, 1, 2048, 2048, 2048},
    '{0,     1, 0, 0,    1,    0,    1},
    '{0,    -1, 0, 1,    0, 2047, 2047},
    '{2,  1024, 0, 0, 1024,    0, 2047},
    '{3, -2047, 0, 0,    0, 2047, 2047},
    '{1,  2047, 0, 1, 2047, 2048, 2047}
  };

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [NUM_CH*DW-1:0]     duty_in = '0;
  logic [NUM_CH-1:0]        duty_wr = '0;
  logic [NUM_CH-1:0]        pol_up  = '0;
  logic [NUM_CH-1:0]        pol_dn  = '0;
  logic [NUM_CH-1:0]        up_o, dn_o;
  logic                     led_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sm_pwm_bank #(.NUM_CH(NUM_CH), .DUTY_W(DW)) u0 (
    .clk(clk), .rst(rst), .duty_in(duty_in), .duty_wr(duty_wr),
    .pol_up(pol_up), .pol_dn(pol_dn), .up_o(up_o), .dn_o(dn_o), .led_o(led_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_ch(input int ch, input int duty, input bit pu, input bit pd);
    @(negedge clk);
    duty_in[ch*DW +: DW] = duty[DW-1:0];
    duty_wr[ch] = 1'b1;
    pol_up[ch]  = pu;
    pol_dn[ch]  = pd;
    @(negedge clk);
    duty_wr = '0;
  endtask

  task automatic measure(input int ch, output int cu, output int cd, output int cl);
    cu = 0; cd = 0; cl = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      cu += int'(up_o[ch]);
      cd += int'(dn_o[ch]);
      cl += int'(led_o);
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cu, cd, cl, bad;
    repeat (4) @(negedge clk);
    // R8: outputs low during reset
    check("R8 in reset", int'({up_o, dn_o, led_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 after reset", int'({up_o, dn_o, led_o}), 0);

    // R7: mid-period write must wait for the counter wrap
    repeat (300) @(negedge clk);
    write_ch(0, 100, 1'b0, 1'b0);
    bad = 0;
    for (int i = 0; i < 1400; i++) begin
      @(negedge clk);
      bad += int'(up_o[0] | dn_o[0]);
    end
    check("R7 held until wrap", bad, 0);
    repeat (400) @(negedge clk);
    measure(0, cu, cd, cl);
    check("R7 after wrap", cu, 100);

    for (int v = 0; v < NV; v++) begin
      write_ch(TBL[v].ch, TBL[v].duty, TBL[v].pu[0], TBL[v].pd[0]);
      repeat (PER + 4) @(negedge clk);
      measure(TBL[v].ch, cu, cd, cl);
      // R1 R2 R3 R4 R9 pin high time; R5 R6 via led
      check($sformatf("R1/R2/R4/R9 up v%0d", v), cu, TBL[v].eu);
      check($sformatf("R1/R2/R3/R9 dn v%0d", v), cd, TBL[v].ed);
      check($sformatf("R5/R6 led v%0d", v), cl, TBL[v].el);
    end

    // R4: polarity change shows on the next clock, independent of wrap
    write_ch(2, 0, 1'b0, 1'b0);
    repeat (PER + 4) @(negedge clk);
    pol_up[2] = 1'b1;
    @(negedge clk);
    check("R4 pol immediate", int'(up_o[2]), 1);
    pol_up[2] = 1'b0;
    @(negedge clk);
    check("R4 pol released", int'(up_o[2]), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule